// File: doc/BRIEF.md
# Host Flash Programming Sequencer

This block sits between a host and a 16-bit parallel flash built from two byte-wide halves. The host presents one request at a time with a valid/ready handshake: program one word, erase one sector, or erase the whole device. The sequencer then drives the flash bus. It issues the unlock and command words as a series of write cycles, with active-low chip selects, output enable and write enable. Every minimum interval is a clock count derived from nanosecond parameters and rounded up.

After the last write it waits out the output-enable hold and then reads the target location repeatedly. It compares the top bit of each byte half with the expected word. For a program the expected word is the requested data; for an erase it is all ones. Completion needs both halves to match. If that does not happen within a host-supplied number of reads, an error pulse is raised in place of the done pulse. Either way the sequencer returns to idle.

Top module: `fseq_top`

## Requirements
- R1: During and after reset the controller is idle: `req_ready` is 1, both chip selects, `fl_we_n` and `fl_oe_n` are high, and `fl_doe` is 0.
- R2: `req_op` 0 (program) produces exactly four write cycles of {address, data}: {5555h, AAAAh}, {2AAAh, 5555h}, {5555h, A0A0h}, {req_addr, req_data}.
- R3: `req_op` 1 (sector erase) produces six write cycles: {5555h, AAAAh}, {2AAAh, 5555h}, {5555h, 8080h}, {5555h, AAAAh}, {2AAAh, 5555h}, {req_addr, 3030h}.
- R4: `req_op` 2 or 3 (chip erase) produces the same first five writes as R3, then {5555h, 1010h}.
- R5: Each write-enable low pulse lasts exactly C_WLOW cycles. Address and data stay stable while it is low and for the following cycle. Consecutive pulses of one request are separated by exactly C_WHIGH + SU_CYC high cycles. With the default bench timing, C_WLOW = 3, C_WHIGH = 2 and SU_CYC = 1.
- R6: Output enable is never low while write enable is low, and the data-out enable is 0 whenever output enable is low.
- R7: Only the chip select of the bank given by `req_bank` (0 = lower, 1 = upper) goes low during a request, and at no time are both chip selects low.
- R8: A poll read counts as complete only when `fl_din[7]` and `fl_din[15]` both equal the same bits of the expected word. One matching half alone is not enough. On completion, `done` pulses for one cycle.
- R9: The expected polled word is `req_data` for a program and FFFFh for either erase. The other bits of `fl_din` have no effect.
- R10: When `poll_limit` reads in a row fail to complete, `err` pulses for one cycle, no further read is made and the controller returns to idle. A request whose last allowed read completes ends with `done`.
- R11: A request is taken only when `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the cycle after acceptance until the request ends, and `req_valid` held during that time starts nothing.
- R12: After the final write-enable rising edge, the first poll read begins exactly C_WHIGH + C_OEH cycles later (C_OEH = 1 in the bench), with output enable high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_op | input | 2 | 0 program, 1 sector erase, 2/3 chip erase |
| req_bank | input | BW | Bank select, 0 lower, 1 upper |
| req_addr | input | 17 | Target word or sector address |
| req_data | input | 16 | Word to program |
| poll_limit | input | PW | Maximum number of poll reads |
| done | output | 1 | One-cycle pulse on completion |
| err | output | 1 | One-cycle pulse on poll timeout |
| fl_addr | output | 17 | Flash address |
| fl_dout | output | 16 | Flash write data |
| fl_doe | output | 1 | Data-out enable |
| fl_din | input | 16 | Flash read data |
| fl_cs_n | output | NB | Active-low bank chip selects |
| fl_oe_n | output | 1 | Active-low output enable |
| fl_we_n | output | 1 | Active-low write enable |

## Verification
All three request kinds are run on both banks, so a wrong script word, a wrong script length or a wrong selected bank shows up in the write scoreboard. The bench's flash model keeps each byte half busy for its own number of reads. Runs where the halves finish together, finish at different times, or where only the low half ever finishes tell a correct two-bit comparison apart from one that checks a single half. Poll counts one below, equal to and above the limit separate an off-by-one timeout from a correct one. A request held valid during a busy operation shows whether the handshake really blocks it.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam int FL_AW = 17;
    localparam int FL_DW = 16;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_CHP2 = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_SETUP, S_WLOW, S_WHIGH, S_OEHOLD, S_READ, S_GAP
    } st_e;

    typedef struct packed {
        logic [FL_AW-1:0] addr;
        logic [FL_DW-1:0] data;
    } bus_word_t;

    localparam logic [FL_AW-1:0] UNLK_A = 17'h05555;
    localparam logic [FL_AW-1:0] UNLK_B = 17'h02AAA;

    function automatic int cdiv(int num, int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [2:0] script_len(op_e op);
        return (op == OP_PROG) ? 3'd4 : 3'd6;
    endfunction

    function automatic logic [FL_DW-1:0] poll_expect(op_e op, logic [FL_DW-1:0] wr);
        return (op == OP_PROG) ? wr : {FL_DW{1'b1}};
    endfunction

    function automatic bus_word_t script_word(op_e op, logic [2:0] idx,
                                              logic [FL_AW-1:0] tgt,
                                              logic [FL_DW-1:0] wr);
        bus_word_t w;
        unique case (idx)
            3'd0:    w = '{UNLK_A, 16'hAAAA};
            3'd1:    w = '{UNLK_B, 16'h5555};
            3'd2:    w = (op == OP_PROG) ? '{UNLK_A, 16'hA0A0} : '{UNLK_A, 16'h8080};
            3'd3:    w = (op == OP_PROG) ? '{tgt, wr} : '{UNLK_A, 16'hAAAA};
            3'd4:    w = '{UNLK_B, 16'h5555};
            default: w = (op == OP_SECT) ? '{tgt, 16'h3030} : '{UNLK_A, 16'h1010};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/fseq_timer.sv
module fseq_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [TW-1:0] len,
    output logic          last
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign last = (cnt == len - 1'b1);
endmodule

// File: rtl/fseq_poll.sv
module fseq_poll #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          sample,
    input  logic          got_lo,
    input  logic          got_hi,
    input  logic          want_lo,
    input  logic          want_hi,
    input  logic [PW-1:0] limit,
    output logic          pass,
    output logic          exhaust
);
    logic [PW-1:0] tally;

    assign pass    = (got_lo == want_lo) && (got_hi == want_hi);
    assign exhaust = ({1'b0, tally} + 1'b1) >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst || clear)          tally <= '0;
        else if (sample && !pass)  tally <= tally + 1'b1;
    end
endmodule

// File: rtl/fseq_top.sv
module fseq_top
    import fseq_pkg::*;
#(
    parameter int CLK_NS = 20,
    parameter int WP_NS  = 25,
    parameter int WPH_NS = 20,
    parameter int AH_NS  = 40,
    parameter int DS_NS  = 25,
    parameter int WC_NS  = 50,
    parameter int OEH_NS = 10,
    parameter int ACC_NS = 50,
    parameter int DF_NS  = 20,
    parameter int SU_CYC = 1,
    parameter int PW     = 16,
    parameter int NB     = 2,
    localparam int BW    = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [BW-1:0]    req_bank,
    input  logic [FL_AW-1:0] req_addr,
    input  logic [FL_DW-1:0] req_data,
    input  logic [PW-1:0]    poll_limit,
    output logic             done,
    output logic             err,
    output logic [FL_AW-1:0] fl_addr,
    output logic [FL_DW-1:0] fl_dout,
    output logic             fl_doe,
    input  logic [FL_DW-1:0] fl_din,
    output logic [NB-1:0]    fl_cs_n,
    output logic             fl_oe_n,
    output logic             fl_we_n
);
    localparam int C_SU    = imax(SU_CYC, 1);
    localparam int C_WLOW  = imax(cdiv(WP_NS, CLK_NS), cdiv(DS_NS, CLK_NS));
    localparam int C_WHIGH = imax(imax(cdiv(WPH_NS, CLK_NS), 1),
                                  imax(cdiv(AH_NS, CLK_NS) - C_WLOW,
                                       cdiv(WC_NS, CLK_NS) - C_WLOW - C_SU));
    localparam int C_OEH   = imax(cdiv(OEH_NS, CLK_NS), 1);
    localparam int C_RD    = cdiv(ACC_NS, CLK_NS) + 1;
    localparam int C_GAP   = imax(cdiv(DF_NS, CLK_NS), 1);
    localparam int C_MAX   = imax(imax(imax(C_SU, C_WLOW), imax(C_WHIGH, C_OEH)),
                                  imax(C_RD, C_GAP));
    localparam int TW      = $clog2(C_MAX + 1) + 1;

    st_e              state, nxt;
    op_e              op_q;
    logic [BW-1:0]    bank_q;
    logic [FL_AW-1:0] addr_q;
    logic [FL_DW-1:0] data_q;
    logic [2:0]       widx;
    bus_word_t        cur;
    logic [FL_DW-1:0] expect_w;
    logic [TW-1:0]    tlen;
    logic             tlast, trestart;
    logic             pass, exhaust, wr_phase, busy;

    assign cur      = script_word(op_q, widx, addr_q, data_q);
    assign expect_w = poll_expect(op_q, data_q);

    always_comb begin
        unique case (state)
            S_SETUP:  tlen = TW'(C_SU);
            S_WLOW:   tlen = TW'(C_WLOW);
            S_WHIGH:  tlen = TW'(C_WHIGH);
            S_OEHOLD: tlen = TW'(C_OEH);
            S_READ:   tlen = TW'(C_RD);
            S_GAP:    tlen = TW'(C_GAP);
            default:  tlen = TW'(1);
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (req_valid) nxt = S_SETUP;
            S_SETUP:  if (tlast) nxt = S_WLOW;
            S_WLOW:   if (tlast) nxt = S_WHIGH;
            S_WHIGH:  if (tlast) nxt = (widx == script_len(op_q) - 3'd1) ? S_OEHOLD : S_SETUP;
            S_OEHOLD: if (tlast) nxt = S_READ;
            S_READ:   if (tlast) nxt = (pass || exhaust) ? S_IDLE : S_GAP;
            S_GAP:    if (tlast) nxt = S_READ;
            default:  nxt = S_IDLE;
        endcase
    end

    assign trestart = (nxt != state) || (state == S_IDLE);

    fseq_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst(rst), .restart(trestart), .len(tlen), .last(tlast)
    );

    fseq_poll #(.PW(PW)) u_poll (
        .clk(clk), .rst(rst),
        .clear(state == S_OEHOLD),
        .sample((state == S_READ) && tlast),
        .got_lo(fl_din[7]), .got_hi(fl_din[15]),
        .want_lo(expect_w[7]), .want_hi(expect_w[15]),
        .limit(poll_limit), .pass(pass), .exhaust(exhaust)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            op_q   <= OP_PROG;
            bank_q <= '0;
            addr_q <= '0;
            data_q <= '0;
            widx   <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            state <= nxt;
            done  <= 1'b0;
            err   <= 1'b0;
            if (state == S_IDLE && req_valid) begin
                op_q   <= op_e'(req_op);
                bank_q <= req_bank;
                addr_q <= req_addr;
                data_q <= req_data;
                widx   <= '0;
            end
            if (state == S_WHIGH && nxt == S_SETUP) widx <= widx + 3'd1;
            if (state == S_READ && tlast) begin
                done <= pass;
                err  <= !pass && exhaust;
            end
        end
    end

    assign busy      = (state != S_IDLE);
    assign req_ready = !busy;
    assign wr_phase  = (state == S_SETUP) || (state == S_WLOW) || (state == S_WHIGH);
    assign fl_doe    = wr_phase;
    assign fl_we_n   = (state != S_WLOW);
    assign fl_oe_n   = (state != S_READ);
    assign fl_addr   = wr_phase ? cur.addr : (busy ? addr_q : '0);
    assign fl_dout   = wr_phase ? cur.data : '0;

    for (genvar g = 0; g < NB; g++) begin : g_cs
        assign fl_cs_n[g] = !(busy && (bank_q == BW'(g)));
    end

    // R7
    cs_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~fl_cs_n));
    // R6
    oe_we_chk: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> fl_oe_n);
    // R6
    oe_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> !fl_doe);
    // R5
    we_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dout)));
    // R11
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
    // R10
    result_chk: assert property (@(posedge clk) disable iff (rst)
        (done || err) |-> (req_ready && !(done && err)));
endmodule

// File: tb/sim_fseq_top.sv
module sim_fseq_top;
    localparam int CLK_PERIOD = 10;
    localparam int T_WLOW  = 3;
    localparam int T_WHIGH = 2;
    localparam int T_SU    = 1;
    localparam int T_OEH   = 1;

    logic        clk = 0, rst = 1;
    logic        req_valid = 0, req_ready;
    logic [1:0]  req_op = 0;
    logic [0:0]  req_bank = 0;
    logic [16:0] req_addr = 0;
    logic [15:0] req_data = 0;
    logic [15:0] poll_limit = 1;
    logic        done, err, fl_doe, fl_oe_n, fl_we_n;
    logic [16:0] fl_addr;
    logic [15:0] fl_dout, fl_din;
    logic [1:0]  fl_cs_n;

    int checks = 0, failures = 0;
    bit finished = 0;

    fseq_top #(.CLK_NS(CLK_PERIOD), .ACC_NS(30)) u0 (
        .clk, .rst, .req_valid, .req_ready, .req_op, .req_bank, .req_addr,
        .req_data, .poll_limit, .done, .err, .fl_addr, .fl_dout, .fl_doe,
        .fl_din, .fl_cs_n, .fl_oe_n, .fl_we_n
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(bit ok, string rq, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // flash model: each byte half busy for its own number of reads
    int          lo_left = 0, hi_left = 0;
    logic [15:0] model_exp = 0;
    always_comb begin
        logic [15:0] m;
        m = model_exp;
        if (lo_left > 0) m[7:0]  = ~m[7:0];
        if (hi_left > 0) m[15:8] = ~m[15:8];
        fl_din = fl_oe_n ? 16'h0 : m;
    end
    always @(posedge fl_oe_n) begin
        if (lo_left > 0) lo_left--;
        if (hi_left > 0) hi_left--;
    end

    // scoreboard queues
    logic [32:0] wq[$];
    string       wtag[$];
    int          rkind[$];
    int          rreads[$];
    string       rtag[$];
    logic [1:0]  exp_cs = 2'b11;

    task automatic push_w(logic [16:0] a, logic [15:0] d, string t);
        wq.push_back({a, d});
        wtag.push_back(t);
    endtask

    task automatic do_op(int op, int bank, logic [16:0] a, logic [15:0] d,
                         int lo, int hi, int lim, bit poke);
        string t;
        int mx;
        t = (op == 0) ? "R2" : (op == 1) ? "R3" : "R4";
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        push_w(17'h05555, 16'hAAAA, t);
        push_w(17'h02AAA, 16'h5555, t);
        if (op == 0) begin
            push_w(17'h05555, 16'hA0A0, t);
            push_w(a, d, t);
        end else begin
            push_w(17'h05555, 16'h8080, t);
            push_w(17'h05555, 16'hAAAA, t);
            push_w(17'h02AAA, 16'h5555, t);
            if (op == 1) push_w(a, 16'h3030, t);
            else         push_w(17'h05555, 16'h1010, t);
        end
        mx = (lo > hi) ? lo : hi;
        if (mx >= lim) begin
            rkind.push_back(2); rreads.push_back(lim); rtag.push_back("R10");
        end else begin
            rkind.push_back(1); rreads.push_back(mx + 1); rtag.push_back("R8");
        end
        model_exp  = (op == 0) ? d : 16'hFFFF;   // R9
        lo_left    = lo;
        hi_left    = hi;
        poll_limit = 16'(lim);
        exp_cs     = (bank == 0) ? 2'b10 : 2'b01;
        req_op = 2'(op); req_bank = 1'(bank); req_addr = a; req_data = d;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk(req_ready == 0, "R11 ready low after accept", req_ready, 0);
        if (poke) begin
            req_op = 2'd1; req_addr = 17'h1FFFF;
            req_valid = 1;
            repeat (15) @(negedge clk);
            chk(req_ready == 0, "R11 ready low while busy", req_ready, 0);
            req_valid = 0;
        end
        while (!(done || err)) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(fl_cs_n == 2'b11 && wq.size() == 0, "R11 no extra activity",
            {fl_cs_n, 8'(wq.size())}, {2'b11, 8'd0});
    endtask

    // monitor
    logic prev_we = 1, prev_oe = 1;
    int   low_cnt = 0, gap = 0, since_rise = 0, nwr = 0, reads = 0;
    bit   first_rd = 1, viol6 = 0, viol7 = 0;
    logic [16:0] cap_a;
    logic [15:0] cap_d;

    always @(negedge clk) begin
        if (!rst) begin
            if (!fl_oe_n && (!fl_we_n || fl_doe)) viol6 = 1;
            if (fl_cs_n == 2'b00) viol7 = 1;
            if (!fl_we_n) begin
                if (prev_we) begin
                    low_cnt = 1;
                    chk(fl_cs_n == exp_cs, "R7 bank select", fl_cs_n, exp_cs);
                    if (nwr > 0) chk(gap == T_WHIGH + T_SU, "R5 high gap", gap, T_WHIGH + T_SU);
                end else low_cnt++;
                cap_a = fl_addr; cap_d = fl_dout;
            end else if (!prev_we) begin
                chk(low_cnt == T_WLOW, "R5 we low width", low_cnt, T_WLOW);
                chk(fl_addr == cap_a, "R5 address hold", fl_addr, cap_a);
                if (wq.size() == 0) chk(0, "R11 unexpected write", {cap_a, cap_d}, 0);
                else begin
                    logic [32:0] e;
                    string tg;
                    e = wq.pop_front(); tg = wtag.pop_front();
                    chk({cap_a, cap_d} == e, tg, {cap_a, cap_d}, e);
                end
                nwr++; gap = 1; since_rise = 0; first_rd = 1;
            end else begin
                gap++; since_rise++;
            end
            if (!fl_oe_n && prev_oe) begin
                reads++;
                if (first_rd)
                    chk(since_rise == T_WHIGH + T_OEH && !fl_doe, "R12 oe hold",
                        since_rise, T_WHIGH + T_OEH);
                first_rd = 0;
            end
            if (done || err) begin
                int k, n;
                string tg;
                k = done ? 1 : 2;
                if (rkind.size() == 0) chk(0, "R11 unexpected result", k, 0);
                else begin
                    int ek;
                    ek = rkind.pop_front(); n = rreads.pop_front(); tg = rtag.pop_front();
                    chk(k == ek && !(done && err), {tg, " result kind"}, k, ek);
                    chk(reads == n, {tg, " poll reads"}, reads, n);
                end
                chk(!viol6, "R6 oe/we/doe exclusion", viol6, 0);
                chk(!viol7, "R7 both selects low", viol7, 0);
                reads = 0; nwr = 0;
            end
            prev_we = fl_we_n; prev_oe = fl_oe_n;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready && fl_cs_n == 2'b11 && fl_we_n && fl_oe_n && !fl_doe && !done && !err,
            "R1 reset outputs", {req_ready, fl_cs_n, fl_we_n, fl_oe_n, fl_doe}, 6'b111110);
        rst = 0;
        @(negedge clk);
        chk(req_ready == 1, "R1 idle after reset", req_ready, 1);
        // R2 program, halves finish at different reads, busy request ignored (R11)
        do_op(0, 0, 17'h12345, 16'h1234, 2, 3, 10, 1);
        // R2 R9 program upper bank, immediate completion
        do_op(0, 1, 17'h1F00F, 16'h8001, 0, 0, 3, 0);
        // R3 sector erase, last allowed read completes (R10 boundary)
        do_op(1, 0, 17'h0C000, 16'h0000, 3, 1, 4, 0);
        // R4 chip erase, timeout exactly at limit (R10)
        do_op(2, 1, 17'h00000, 16'h0000, 5, 5, 5, 0);
        // R8 only low half finishes -> timeout
        do_op(0, 0, 17'h00777, 16'h7F80, 0, 20, 6, 0);
        // R8 only high half finishes early, low late but within limit
        do_op(3, 0, 17'h00000, 16'h0000, 4, 0, 8, 0);
        // R9 program data with bit7/bit15 mixed, other bits inverted while busy
        do_op(0, 1, 17'h00042, 16'h0080, 1, 2, 5, 0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule